// File: doc/BRIEF.md
# Short Frame Pad and CRC Appender

This block sits in a byte-wide transmit stream that uses a valid/ready handshake and start/end-of-frame markers. Payload bytes pass through it unchanged and without added latency. When the last payload byte arrives, the block decides whether the frame needs anything appended. A frame whose payload is too short for the Ethernet minimum of 64 bytes, frame check sequence included, can be extended with zero bytes up to 60 bytes. A four-byte CRC-32 frame check sequence can then be added after the payload and any padding.

Two per-frame controls travel alongside the first byte of every frame. One suppresses padding and the other suppresses the CRC. The block captures both on the start-of-frame beat and ignores their values on every later beat of the same frame. If padding is actually inserted, the CRC is always appended, whatever the CRC-suppress control says. While padding and CRC bytes are being emitted, the block stalls its upstream side.

Top module: `tx_pad_fcs`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is low with no input offered, and in_ready follows out_ready.
- R2: Payload bytes appear on out_data unchanged and in order, and out_sof is high only on the first output byte of a frame.
- R3: When in_no_pad was 0 at frame start and the frame has fewer than 60 payload bytes, zero-valued bytes follow the payload until payload plus padding equals exactly 60 bytes, and the CRC follows them.
- R4: If padding is inserted, the 4-byte CRC is appended even when in_no_crc was 1 at frame start.
- R5: When in_no_crc was 1 at frame start and no padding is inserted, nothing is appended, and out_eof is asserted on the last payload byte.
- R6: When in_no_pad was 1 at frame start, a short frame gets no padding, and it gets the CRC exactly when in_no_crc was 0.
- R7: A frame of 60 or more payload bytes never gets padding, and it gets the CRC exactly when in_no_crc was 0.
- R8: The CRC is the IEEE 802.3 CRC-32: reflected polynomial 0xEDB88320, all-ones start value, and the result complemented. It covers the payload and the padding and is sent least significant byte first. The 9-byte ASCII payload "123456789" is followed by 0x26, 0x39, 0xF4, 0xCB.
- R9: in_no_pad and in_no_crc are sampled only on the accepted beat where in_sof is 1. Their values on other beats of the frame have no effect.
- R10: After an end-of-frame input byte is accepted that is not the final output byte, in_ready stays low until the final appended byte has been sent. out_eof is high only on the final output byte of each frame.
- R11: While out_valid is high and out_ready is low, out_valid, out_data and out_eof hold their values into the next cycle.
- R12: The internal byte count saturates at 2^CNT_W-1, so a frame longer than the counter range is still treated as long: no padding, and the CRC is added according to in_no_crc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block can accept an upstream byte |
| in_data | input | 8 | Upstream payload byte |
| in_sof | input | 1 | Upstream byte is the first of a frame |
| in_eof | input | 1 | Upstream byte is the last payload byte of a frame |
| in_no_pad | input | 1 | Padding suppress, sampled with in_sof |
| in_no_crc | input | 1 | CRC suppress, sampled with in_sof |
| out_valid | output | 1 | Downstream byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Downstream byte: payload, padding or CRC |
| out_sof | output | 1 | Downstream byte is the first of a frame |
| out_eof | output | 1 | Downstream byte is the last of a frame |

## Verification
The bench builds the block with CNT_W set to 7, so the byte counter tops out at 127. A 200-byte frame therefore drives the counter into saturation and shows that long frames still skip padding after the count stops. MIN_FRAME keeps its default of 64. This places the 59/60 payload-length boundary and the padding span well inside the 7-bit range. With that setting, single-byte frames, frames right at the boundary, and flag toggling on later beats can all be reached under a fixed downstream backpressure pattern.

// File: rtl/txpad_pkg.sv
package txpad_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

  // One byte through the reflected CRC-32 register, LSB of the byte first.
  function automatic logic [31:0] crc_byte(input logic [31:0] crc_in, input logic [7:0] b);
    logic [31:0] c;
    logic        fb;
    c = crc_in;
    for (int k = 0; k < 8; k++) begin
      fb = c[0] ^ b[k];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/txpad_rst_sync.sv
module txpad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/txpad_len_cnt.sv
module txpad_len_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (start)               cnt_next_o = CNT_ONE;
    else if (cnt_q == CNT_MAX) cnt_next_o = CNT_MAX;
    else                     cnt_next_o = cnt_q + CNT_ONE;
    cnt_d = step ? cnt_next_o : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R12
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && step && !start) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/txpad_crc32.sv
module txpad_crc32
  import txpad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        step,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;
  logic [31:0] crc_d;
  logic [31:0] crc_base;

  always_comb begin
    crc_base = start ? CRC_SEED : crc_q;
    crc_d    = step ? crc_byte(crc_base, byte_i) : crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  // R8
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(crc_q));
endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
  import txpad_pkg::*;
#(
  parameter int MIN_FRAME  = 64,
  parameter int CNT_W      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_no_pad,
  input  logic       in_no_crc,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  localparam int FCS_BYTES = 4;
  localparam int IDX_W     = $clog2(FCS_BYTES);
  localparam int MIN_DATA  = MIN_FRAME - FCS_BYTES;
  localparam logic [CNT_W-1:0] MIN_DATA_C = CNT_W'(MIN_DATA);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(FCS_BYTES - 1);

  logic             rst_q_n;
  tx_state_e        state_q, state_d;
  logic             np_q, np_d, nc_q, nc_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cnt_start, cnt_step;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             crc_step;
  logic [7:0]       crc_in;
  logic [31:0]      crc_q, fcs_word;
  logic             eff_np, eff_nc, is_short, add_pad, add_fcs;

  txpad_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  txpad_len_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .start(cnt_start), .step(cnt_step),
    .cnt_o(cnt_q), .cnt_next_o(cnt_next)
  );

  txpad_crc32 u_crc (
    .clk(clk), .rst_n(rst_q_n), .start(cnt_start), .step(crc_step),
    .byte_i(crc_in), .crc_o(crc_q)
  );

  // Frame start restarts length and CRC; only meaningful in the data phase.
  assign cnt_start = (state_q == ST_DATA) && in_sof;
  assign fcs_word  = ~crc_q;

  // Flag resolution for the byte now at the input.
  always_comb begin
    eff_np   = in_sof ? in_no_pad : np_q;
    eff_nc   = in_sof ? in_no_crc : nc_q;
    is_short = cnt_next < MIN_DATA_C;
    add_pad  = is_short && !eff_np;
    add_fcs  = add_pad || !eff_nc;
  end

  always_comb begin
    state_d   = state_q;
    np_d      = np_q;
    nc_d      = nc_q;
    idx_d     = idx_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_sof   = 1'b0;
    out_eof   = 1'b0;
    cnt_step  = 1'b0;
    crc_step  = 1'b0;
    crc_in    = in_data;
    case (state_q)
      ST_DATA: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_sof   = in_sof;
        out_eof   = in_eof && !add_fcs;
        if (in_valid && out_ready) begin
          cnt_step = 1'b1;
          crc_step = 1'b1;
          if (in_sof) begin
            np_d = in_no_pad;
            nc_d = in_no_crc;
          end
          if (in_eof) begin
            idx_d = '0;
            if (add_pad)      state_d = ST_PAD;
            else if (add_fcs) state_d = ST_FCS;
          end
        end
      end
      ST_PAD: begin
        out_valid = 1'b1;
        crc_in    = 8'h00;
        if (out_ready) begin
          cnt_step = 1'b1;
          crc_step = 1'b1;
          if (cnt_next >= MIN_DATA_C) state_d = ST_FCS;
        end
      end
      ST_FCS: begin
        out_valid = 1'b1;
        out_data  = fcs_word[{idx_q, 3'b000} +: 8];
        out_eof   = (idx_q == IDX_LAST);
        if (out_ready) begin
          if (idx_q == IDX_LAST) begin
            idx_d   = '0;
            state_d = ST_DATA;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_DATA;
      np_q    <= 1'b0;
      nc_q    <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      np_q    <= np_d;
      nc_q    <= nc_d;
      idx_q   <= idx_d;
    end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

  // R10
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_ready && in_eof && !out_eof) |=> !in_ready);

  // R3
  pad_bound_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_PAD) |-> (cnt_q < MIN_DATA_C));

  // R3
  pad_exit_len_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_FCS && $past(state_q) == ST_PAD) |-> (cnt_q == MIN_DATA_C));

  // R4
  pad_then_fcs_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_PAD) |=> (state_q != ST_DATA));
endmodule

// File: tb/tx_pad_fcs_bench.sv
`timescale 1ns/1ps
module tx_pad_fcs_bench;
  localparam int NVEC = 11;
  // Entry: [15:8] payload length, [2] no_pad, [1] no_crc, [0] flip flags on later beats
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd1,  5'd0, 3'b000},   // R3 single byte padded
    {8'd1,  5'd0, 3'b010},   // R4 pad forces CRC
    {8'd10, 5'd0, 3'b100},   // R6 no pad, CRC
    {8'd10, 5'd0, 3'b110},   // R6 nothing appended
    {8'd59, 5'd0, 3'b001},   // R3 R9 one pad byte, flags flipped later
    {8'd60, 5'd0, 3'b000},   // R7 boundary, CRC only
    {8'd60, 5'd0, 3'b010},   // R5 boundary, nothing
    {8'd61, 5'd0, 3'b111},   // R5 R9
    {8'd64, 5'd0, 3'b000},   // R7
    {8'd20, 5'd0, 3'b011},   // R9 later beats claim no_pad
    {8'd59, 5'd0, 3'b101}    // R6 R9
  };

  logic clk, rst_n;
  logic in_valid, in_ready, in_sof, in_eof, in_no_pad, in_no_crc;
  logic [7:0] in_data, out_data;
  logic out_valid, out_ready, out_sof, out_eof;

  int checks = 0, errors = 0;
  int got_n = 0, eof_cnt = 0, hold_bad = 0, stall_seen = 0, ready_bad = 0;
  logic [7:0] got_d [2048];
  logic       got_e [2048];
  logic       got_s [2048];
  logic [7:0] exp_d [256];
  logic [7:0] dat   [256];
  int   exp_n;
  bit   hold_pend = 0, appending = 0, bp_en = 0;
  logic [7:0] hold_data;
  int   cyc = 0;

  tx_pad_fcs #(.MIN_FRAME(64), .CNT_W(7), .RST_STAGES(2)) u_tx_pad_fcs (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_no_pad(in_no_pad), .in_no_crc(in_no_crc), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = !bp_en || ((cyc % 5) != 2 && (cyc % 7) != 3);
    end
  end

  always @(negedge clk) begin
    if (hold_pend && !(out_valid && out_data == hold_data)) hold_bad++;
    hold_pend = out_valid && !out_ready;
    hold_data = out_data;
    if (hold_pend) stall_seen++;
    if (appending && in_ready) ready_bad++;
    if (out_valid && out_ready) begin
      if (got_n < 2048) begin
        got_d[got_n] = out_data; got_e[got_n] = out_eof; got_s[got_n] = out_sof;
      end
      got_n++;
      if (out_eof) begin eof_cnt++; appending = 0; end
    end
    if (in_valid && in_ready && in_eof && !out_eof) appending = 1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        if ((c[0] ^ exp_d[i][k]) == 1'b1) c = (c >> 1) ^ 32'hEDB8_8320;
        else                              c = c >> 1;
    return ~c;
  endfunction

  task automatic send_byte(input logic [7:0] d, input bit s, input bit e, input bit np, input bit nc);
    bit acc;
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_no_pad = np; in_no_crc = nc;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run_frame(input int len, input bit np, input bit nc, input bit flip,
                           input bit ascii, input int seed, input string tag);
    int base, e0, bad, sofs, eofs;
    logic [31:0] c;
    bit pad, fcs;
    for (int i = 0; i < len; i++)
      dat[i] = ascii ? 8'(8'h31 + i) : 8'((i * 37 + seed * 11 + 5) & 8'hFF);
    for (int i = 0; i < len; i++) exp_d[i] = dat[i];
    exp_n = len;
    pad = (len < 60) && !np;
    fcs = pad || !nc;
    if (pad) begin
      for (int i = len; i < 60; i++) exp_d[i] = 8'h00;
      exp_n = 60;
    end
    if (fcs) begin
      c = ref_crc(exp_n);
      for (int k = 0; k < 4; k++) exp_d[exp_n + k] = c[8*k +: 8];
      exp_n += 4;
    end
    base = got_n; e0 = eof_cnt;
    for (int i = 0; i < len; i++) begin
      if (i == 0)   send_byte(dat[i], 1'b1, i == len - 1, np, nc);
      else if (flip) send_byte(dat[i], 1'b0, i == len - 1, !np, !nc);
      else          send_byte(dat[i], 1'b0, i == len - 1, np, nc);
    end
    while (eof_cnt == e0) @(posedge clk);
    #1;
    check(got_n - base == exp_n, tag, "frame length", got_n - base, exp_n);
    bad = 0; sofs = 0; eofs = 0;
    for (int i = 0; i < exp_n && i < got_n - base; i++) begin
      if (got_d[base + i] != exp_d[i]) bad++;
      if (got_s[base + i] != (i == 0)) sofs++;
      if (got_e[base + i] != (i == exp_n - 1)) eofs++;
    end
    check(bad == 0, tag, "byte mismatches", bad, 0);
    check(sofs == 0 && eofs == 0, tag, "R2 R10 marker errors", sofs + eofs, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    in_no_pad = 1'b0; in_no_crc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == out_ready, "R1", "idle after reset", {out_valid, in_ready}, {1'b0, out_ready});
    @(posedge clk); #1;
    bp_en = 1;

    for (int v = 0; v < NVEC; v++)
      run_frame(int'(VEC[v][15:8]), VEC[v][2], VEC[v][1], VEC[v][0], 1'b0, v, $sformatf("R2 R3 R9 vec%0d", v));

    // R8 known check value after nine ASCII digits
    b = got_n;
    run_frame(9, 1'b1, 1'b0, 1'b0, 1'b1, 0, "R8 ascii");
    check({got_d[b+12], got_d[b+11], got_d[b+10], got_d[b+9]} == 32'hCBF4_3926,
          "R8", "fcs bytes", {got_d[b+12], got_d[b+11], got_d[b+10], got_d[b+9]}, 32'hCBF4_3926);

    // R12 counter saturates, long frame unpadded
    run_frame(200, 1'b0, 1'b0, 1'b0, 1'b0, 3, "R12 long");
    // R5 single byte with both suppressions
    run_frame(1, 1'b1, 1'b1, 1'b0, 1'b0, 4, "R5 single");
    // R4 R6 R7 extra mixes
    run_frame(2, 1'b0, 1'b1, 1'b1, 1'b0, 5, "R4 flip");
    run_frame(100, 1'b1, 1'b0, 1'b0, 1'b0, 6, "R7 long");

    check(hold_bad == 0 && stall_seen > 0, "R11", "hold violations", hold_bad, 0);
    check(ready_bad == 0, "R10", "in_ready high while appending", ready_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule